// File: doc/BRIEF.md
# Floppy Controller Phase Sequencer

This block steps a single-drive floppy controller through its command, execution and result phases. A host reaches it through a byte-wide register window addressed by three bits. Offset 2 is a read/write drive control byte, offset 4 reads back the phase status byte, and offset 5 is the shared data port. The host writes an opcode and its parameter bytes to the data port. The block then runs the command and presents the result bytes on the same port. It raises an interrupt line at the points a driver expects. The host can poll the status byte before each data-port access, or it can wait for the interrupt.

Sector data for reads can be taken by programmed I/O through the data port. A built-in stub produces a fixed byte pattern in place of a real disk. The supported commands are data read, verify, read-ID, absolute seek, relative seek in either direction, and sense-interrupt. Drive mechanics, encoding, CRC and a real DMA handshake are not modelled. All transfers complete as soon as the host is ready. The only exception is read-ID, which takes a configurable number of execution cycles.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset, the status byte (offset 4) reads 0x80, the interrupt is low and the control byte (offset 2) reads 0x08.
- R2: Opcodes are decoded with these parameter byte counts: 0xE6 read (8), 0x16 verify (8), 0x0A read-ID (1), 0x0F seek (2), 0xCF relative seek inward (2), 0x8F relative seek outward (2), 0x08 sense-interrupt (0). Any other opcode gives one result byte, 0x80.
- R3: While parameter bytes are still expected, the status byte reads 0x90 and the interrupt stays low.
- R4: A seek sets the present cylinder to its second parameter byte. Inward relative seek adds the count and saturates at 255. Outward relative seek subtracts the count and saturates at 0. Both raise the interrupt and return the status byte to 0x80 with no result phase.
- R5: Sense-interrupt with a seek completion pending returns two bytes: 0x20|(first seek parameter & 7), then the present cylinder. With nothing pending it returns the single byte 0x80.
- R6: Read or verify with no media enters the result phase (status 0xD0, interrupt high). It returns 0x40|(unit byte & 7), 0x01, 0x00, cylinder, head, start sector, size.
- R7: A read (0xE6) with media present and control bit 3 clear enters a data phase with status 0xF0. There the host reads 512 bytes per sector, from the start sector to the end sector. Byte j of sector s equals (s + j) mod 256.
- R8: When the last data byte is read, the result phase begins with the interrupt high. With opcode bit 7 set, the head is reported flipped: status 0 carries the inverted head bit, H = head^1 and R = 1. Without bit 7, H = head and R = end sector + 1. Result bytes 2 and 3 are 0.
- R9: If the end sector exceeds 18, the transfer stops after sector 18. The result is then 0x40|(unit & 7), 0x80, 0x00, cylinder, head, 18, size.
- R10: A verify, or a read with control bit 3 set, skips the data phase and reports the same result as R8 or R9 at once.
- R11: Read-ID holds the status byte at 0x10 with the interrupt low for its execution time. It then returns (unit & 7), 0, 0, present cylinder, head bit, 1, 2, with the interrupt high.
- R12: The interrupt stays high through all result bytes. It drops, and the status byte returns to 0x80, once the last result byte is read. Writing any opcode also clears it.
- R13: A data-port write while the status direction bit (0x40) is set is ignored, and so is any write while the ready bit (0x80) is clear. A data-port read while the direction bit is clear returns 0x00. Neither advances the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| media_present | input | 1 | Media inserted in the drive |

## Verification
The read command is tried four ways: with no media, by programmed I/O within the track, by programmed I/O running past the track end, and with the data phase skipped (DMA setting and verify). These runs separate the abnormal, head-flip, end-of-cylinder and plain end rules. The data pattern depends on both sector and byte index, so a missed or doubled byte shows up at once. Seeks are read back through sense-interrupt, both absolute and relative in both directions, including saturation at cylinder 0. This checks that the present cylinder and the pending flag travel together. Misdirected port accesses are placed in the middle of result and command phases, so any skipped or repeated result byte exposes a wrongly advanced counter.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
   typedef enum logic [2:0] {PH_CMD, PH_PARAM, PH_EXEC, PH_DATA, PH_RES} phase_t;
   typedef enum logic [2:0] {K_READ, K_VERIFY, K_RDID, K_SEEK, K_RSEEK, K_SENSE, K_BAD} kind_t;

   localparam logic [7:0] OP_SENSE  = 8'h08;
   localparam logic [7:0] OP_RDID   = 8'h0A;
   localparam logic [7:0] OP_SEEK   = 8'h0F;
   localparam logic [7:0] OP_VERIFY = 8'h16;
   localparam logic [7:0] OP_READ   = 8'hE6;
   localparam logic [7:0] OP_RS_OUT = 8'h8F;
   localparam logic [7:0] OP_RS_IN  = 8'hCF;

   // status byte values per phase
   localparam logic [7:0] ST_IDLE  = 8'h80;
   localparam logic [7:0] ST_PARAM = 8'h90;
   localparam logic [7:0] ST_EXEC  = 8'h10;
   localparam logic [7:0] ST_PIO   = 8'hF0;
   localparam logic [7:0] ST_RES   = 8'hD0;

   localparam int RES_MAX = 7;
   localparam int PAR_KEEP = 5;
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
   import fdc_pkg::*;
(
   input  logic [7:0] op,
   output kind_t      kind,
   output logic [3:0] n_par
);
   always_comb begin
      case (op)
         OP_READ:   begin kind = K_READ;   n_par = 4'd8; end
         OP_VERIFY: begin kind = K_VERIFY; n_par = 4'd8; end
         OP_RDID:   begin kind = K_RDID;   n_par = 4'd1; end
         OP_SEEK:   begin kind = K_SEEK;   n_par = 4'd2; end
         OP_RS_IN,
         OP_RS_OUT: begin kind = K_RSEEK;  n_par = 4'd2; end
         OP_SENSE:  begin kind = K_SENSE;  n_par = 4'd0; end
         default:   begin kind = K_BAD;    n_par = 4'd0; end
      endcase
   end
endmodule

// File: rtl/fdc_exec_timer.sv
module fdc_exec_timer #(
   parameter int CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   generate
      if (CYCLES <= 1) begin : g_instant
         assign expired = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(CYCLES + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
         end
         assign expired = run && (cnt_q == CNT_W'(CYCLES - 1));
      end
   endgenerate
endmodule

// File: rtl/fdc_sector_src.sv
module fdc_sector_src #(
   parameter int IDX_W = 9
) (
   input  logic [7:0]       sector,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       data
);
   assign data = 8'(int'(idx) + int'(sector));
endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
   import fdc_pkg::*;
#(
   parameter int          SECT_BYTES      = 512,
   parameter int          SECTS_PER_TRACK = 18,
   parameter int          RDID_CYCLES     = 40,
   parameter logic [7:0]  CTL_RESET       = 8'h08
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq,
   input  logic       media_present
);
   localparam int         IDX_W = $clog2(SECT_BYTES);
   localparam logic [7:0] SPT8  = 8'(SECTS_PER_TRACK);

   generate
      if (SECT_BYTES < 2 || (SECT_BYTES & (SECT_BYTES - 1)) != 0) begin : g_bad_sb
         $error("SECT_BYTES must be a power of two");
      end
      if (SECTS_PER_TRACK < 1 || SECTS_PER_TRACK > 254) begin : g_bad_spt
         $error("SECTS_PER_TRACK out of range");
      end
   endgenerate

   phase_t                     phase_q;
   kind_t                      kind_q, dec_kind;
   logic [3:0]                 npar_q, dec_npar;
   logic [2:0]                 pcnt_q;
   logic                       mt_q, inward_q;
   logic [2:0]                 unit_q, seek_unit_q;
   logic [PAR_KEEP-1:0][7:0]   par_q;   // cyl, head, sector, size, end sector
   logic [RES_MAX-1:0][7:0]    res_q, rw_res, id_res;
   logic [2:0]                 rcnt_q, rtot_q;
   logic [7:0]                 sec_q, pcn_q, ctl_q, stat, src_byte, last_sec;
   logic [IDX_W-1:0]           idx_q;
   logic                       int_pend_q, irq_q, tmr_done, over;
   logic                       fifo_wr, fifo_rd, acc_wr, acc_rd;
   logic [8:0]                 up_sum;

   fdc_cmd_decode u_dec (.op(bus_wdata), .kind(dec_kind), .n_par(dec_npar));

   fdc_exec_timer #(.CYCLES(RDID_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .run(phase_q == PH_EXEC && kind_q == K_RDID),
      .expired(tmr_done));

   fdc_sector_src #(.IDX_W(IDX_W)) u_src (.sector(sec_q), .idx(idx_q), .data(src_byte));

   always_comb begin
      case (phase_q)
         PH_PARAM: stat = ST_PARAM;
         PH_EXEC:  stat = ST_EXEC;
         PH_DATA:  stat = ST_PIO;
         PH_RES:   stat = ST_RES;
         default:  stat = ST_IDLE;
      endcase
   end

   assign fifo_wr = bus_wr && bus_addr == 3'd5;
   assign fifo_rd = bus_rd && bus_addr == 3'd5;
   assign acc_wr  = fifo_wr && stat[7] && !stat[6];
   assign acc_rd  = fifo_rd && stat[7] && stat[6];

   always_comb begin
      bus_rdata = 8'h00;
      case (bus_addr)
         3'd2: bus_rdata = ctl_q;
         3'd4: bus_rdata = stat;
         3'd5: if (phase_q == PH_DATA)     bus_rdata = src_byte;
               else if (phase_q == PH_RES) bus_rdata = res_q[rcnt_q];
         default: ;
      endcase
   end

   // result of a read/verify, shared by the PIO and no-data-phase paths
   assign over     = par_q[4] > SPT8;
   assign last_sec = over ? SPT8 : par_q[4];
   always_comb begin
      rw_res[3] = par_q[0];
      rw_res[6] = par_q[3];
      rw_res[2] = 8'h00;
      rw_res[4] = par_q[1];
      if (!media_present) begin
         rw_res[0] = {5'b01000, unit_q};
         rw_res[1] = 8'h01;
         rw_res[5] = par_q[2];
      end else if (over) begin
         rw_res[0] = {5'b01000, unit_q};
         rw_res[1] = 8'h80;
         rw_res[5] = SPT8;
      end else if (mt_q) begin
         rw_res[0] = {5'b00000, ~unit_q[2], unit_q[1:0]};
         rw_res[1] = 8'h00;
         rw_res[4] = par_q[1] ^ 8'h01;
         rw_res[5] = 8'h01;
      end else begin
         rw_res[0] = {5'b00000, unit_q};
         rw_res[1] = 8'h00;
         rw_res[5] = last_sec + 8'h01;
      end
   end

   assign id_res = {8'h02, 8'h01, {7'b0, unit_q[2]}, pcn_q, 8'h00, 8'h00, {5'b0, unit_q}};
   assign up_sum = {1'b0, pcn_q} + {1'b0, par_q[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;   kind_q <= K_BAD;    npar_q <= '0;
         pcnt_q <= '0;        mt_q <= 1'b0;       inward_q <= 1'b0;
         unit_q <= '0;        seek_unit_q <= '0;  par_q <= '0;
         res_q <= '0;         rcnt_q <= '0;       rtot_q <= 3'd1;
         sec_q <= '0;         pcn_q <= '0;        idx_q <= '0;
         ctl_q <= CTL_RESET;  int_pend_q <= 1'b0; irq_q <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == 3'd2) ctl_q <= bus_wdata;
         case (phase_q)
            PH_CMD: if (acc_wr) begin
               kind_q <= dec_kind;  npar_q <= dec_npar;  pcnt_q <= '0;
               mt_q <= bus_wdata[7];  inward_q <= bus_wdata[6];
               irq_q <= 1'b0;  rcnt_q <= '0;
               if (dec_kind == K_SENSE && int_pend_q) begin
                  res_q[0] <= {5'b00100, seek_unit_q};
                  res_q[1] <= pcn_q;
                  rtot_q <= 3'd2;  int_pend_q <= 1'b0;  phase_q <= PH_RES;
               end else if (dec_kind == K_SENSE || dec_kind == K_BAD) begin
                  res_q[0] <= 8'h80;  rtot_q <= 3'd1;  phase_q <= PH_RES;
               end else begin
                  phase_q <= PH_PARAM;
               end
            end
            PH_PARAM: if (acc_wr) begin
               if (pcnt_q == 3'd0) unit_q <= bus_wdata[2:0];
               else if (pcnt_q <= 3'(PAR_KEEP)) par_q[pcnt_q - 3'd1] <= bus_wdata;
               pcnt_q <= pcnt_q + 3'd1;
               if (pcnt_q == 3'(npar_q - 4'd1)) phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               case (kind_q)
                  K_SEEK, K_RSEEK: begin
                     if (kind_q == K_SEEK)  pcn_q <= par_q[0];
                     else if (inward_q)     pcn_q <= up_sum[8] ? 8'hFF : up_sum[7:0];
                     else                   pcn_q <= (pcn_q < par_q[0]) ? 8'h00 : pcn_q - par_q[0];
                     seek_unit_q <= unit_q;  int_pend_q <= 1'b1;  irq_q <= 1'b1;
                     phase_q <= PH_CMD;
                  end
                  K_RDID: if (tmr_done) begin
                     res_q <= id_res;  rtot_q <= 3'd7;  rcnt_q <= '0;
                     irq_q <= 1'b1;    phase_q <= PH_RES;
                  end
                  K_READ, K_VERIFY: begin
                     if (kind_q == K_READ && media_present && !ctl_q[3]) begin
                        sec_q <= par_q[2];  idx_q <= '0;  phase_q <= PH_DATA;
                     end else begin
                        res_q <= rw_res;  rtot_q <= 3'd7;  rcnt_q <= '0;
                        irq_q <= 1'b1;    phase_q <= PH_RES;
                     end
                  end
                  default: phase_q <= PH_CMD;
               endcase
            end
            PH_DATA: if (acc_rd) begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_W'(SECT_BYTES - 1)) begin
                  if (sec_q >= last_sec) begin
                     res_q <= rw_res;  rtot_q <= 3'd7;  rcnt_q <= '0;
                     irq_q <= 1'b1;    phase_q <= PH_RES;
                  end else begin
                     sec_q <= sec_q + 8'd1;
                  end
               end
            end
            PH_RES: if (acc_rd) begin
               rcnt_q <= rcnt_q + 3'd1;
               if (rcnt_q == rtot_q - 3'd1) begin
                  phase_q <= PH_CMD;  irq_q <= 1'b0;
               end
            end
            default: phase_q <= PH_CMD;
         endcase
      end
   end

   assign irq = irq_q;

   // R3: no interrupt while parameters are being taken
   a_r3_param_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_PARAM |-> !irq_q);

   // R13: a write against the direction bit leaves the sequencer where it was
   a_r13_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && !bus_rd && stat[6]) |=> $stable(phase_q) && $stable(pcnt_q) && $stable(rcnt_q));

   // R12: last result byte ends the phase and drops the interrupt
   a_r12_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RES && acc_rd && rcnt_q == rtot_q - 3'd1) |=> (phase_q == PH_CMD && !irq_q));

   // R11: read-ID execution keeps the interrupt low
   a_r11_rdid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_EXEC && kind_q == K_RDID) |-> !irq_q);

   // R7: data index only moves on an accepted read
   a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA && !acc_rd) |=> (phase_q == PH_DATA && $stable(idx_q) && $stable(sec_q)));

   // R4: interrupt only rises into the result phase or back to command phase
   a_r4_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> (phase_q == PH_RES || phase_q == PH_CMD));

   // R12: result counter stays inside the result set
   a_r12_res_bound: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_RES |-> rcnt_q < rtot_q);
endmodule

// File: tb/fdc_phase_seq_tb.sv
module fdc_phase_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq;
   logic       media_present = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fdc_phase_seq #(.SECT_BYTES(512), .SECTS_PER_TRACK(18), .RDID_CYCLES(40), .CTL_RESET(8'h08)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .media_present(media_present));

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(tag, int'(d), int'(exp));
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic send_rw(input logic [7:0] op, input logic [7:0] unit, input logic [7:0] cyl,
                          input logic [7:0] hd, input logic [7:0] sec, input logic [7:0] eot);
      wr(5, op); wr(5, unit); wr(5, cyl); wr(5, hd); wr(5, sec);
      wr(5, 8'h02); wr(5, eot); wr(5, 8'h1b); wr(5, 8'hff);
      settle();
   endtask

   task automatic expect_res7(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4,
                              input logic [7:0] b5, input logic [7:0] b6);
      logic [7:0] exp [7];
      exp = '{b0, b1, b2, b3, b4, b5, b6};
      for (int i = 0; i < 7; i++) begin
         if (i == 6) check({tag, " R12 irq before last"}, int'(irq), 1);
         expect_reg($sformatf("%s byte%0d", tag, i), 5, exp[i]);
      end
      settle();
      check({tag, " R12 irq dropped"}, int'(irq), 0);
      expect_reg({tag, " R12 idle status"}, 4, 8'h80);
   endtask

   task automatic sense_expect(input string tag, input logic [7:0] st0, input logic [7:0] cyl);
      wr(5, 8'h08);
      check({tag, " R12 opcode clears irq"}, int'(irq), 0);
      expect_reg({tag, " R5 st0"}, 5, st0);
      expect_reg({tag, " R5 cyl"}, 5, cyl);
      expect_reg({tag, " R5 idle"}, 4, 8'h80);
   endtask

   task automatic t_reset();
      expect_reg("R1 status", 4, 8'h80);
      check("R1 irq", int'(irq), 0);
      expect_reg("R1 control", 2, 8'h08);
   endtask

   task automatic t_bad_and_sense_idle();
      wr(5, 8'h55);
      expect_reg("R2 bad op status", 4, 8'hD0);
      expect_reg("R2 bad op byte", 5, 8'h80);
      expect_reg("R2 bad op idle", 4, 8'h80);
      wr(5, 8'h08);
      expect_reg("R5 no pending byte", 5, 8'h80);
      expect_reg("R5 no pending idle", 4, 8'h80);
   endtask

   task automatic t_no_media();
      logic [7:0] d;
      media_present = 1'b0;
      wr(5, 8'hE6);
      expect_reg("R3 status after opcode", 4, 8'h90);
      wr(5, 8'h00);
      check("R3 irq low in params", int'(irq), 0);
      wr(5, 8'h03); wr(5, 8'h00); wr(5, 8'h05); wr(5, 8'h02);
      expect_reg("R3 status mid params", 4, 8'h90);
      wr(5, 8'h09); wr(5, 8'h1b); wr(5, 8'hff);
      settle();
      expect_reg("R6 result status", 4, 8'hD0);
      check("R6 irq high", int'(irq), 1);
      expect_reg("R6 st0", 5, 8'h40);
      // R13: write against direction bit must not advance the result counter
      wr(5, 8'h0F);
      expect_reg("R13 st1 after bad write", 5, 8'h01);
      expect_reg("R6 st2", 5, 8'h00);
      expect_reg("R6 cyl", 5, 8'h03);
      expect_reg("R6 head", 5, 8'h00);
      expect_reg("R6 sector", 5, 8'h05);
      check("R12 irq before last", int'(irq), 1);
      expect_reg("R6 size", 5, 8'h02);
      settle();
      check("R12 irq dropped", int'(irq), 0);
      expect_reg("R12 idle", 4, 8'h80);
      rd(5, d);
      check("R13 read in command phase", int'(d), 0);
      expect_reg("R13 still idle", 4, 8'h80);
   endtask

   task automatic t_seeks();
      wr(5, 8'h0F); wr(5, 8'h04); wr(5, 8'h05);
      settle();
      check("R4 seek irq", int'(irq), 1);
      expect_reg("R4 seek idle", 4, 8'h80);
      sense_expect("R4 seek", 8'h24, 8'h05);
      wr(5, 8'hCF); wr(5, 8'h00); wr(5, 8'h03);
      settle();
      check("R4 rseek in irq", int'(irq), 1);
      sense_expect("R4 rseek in", 8'h20, 8'h08);
      wr(5, 8'h8F); wr(5, 8'h01); wr(5, 8'h0A);
      settle();
      sense_expect("R4 rseek out saturate", 8'h21, 8'h00);
   endtask

   task automatic t_read_id();
      int cyc;
      wr(5, 8'h0F); wr(5, 8'h04); wr(5, 8'h08);
      settle();
      sense_expect("R11 prep", 8'h24, 8'h08);
      wr(5, 8'h0A);
      wr(5, 8'h04);
      expect_reg("R11 exec status", 4, 8'h10);
      check("R11 irq low in exec", int'(irq), 0);
      cyc = 0;
      while (!irq && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      check("R11 irq appears", int'(irq), 1);
      check("R11 exec long enough", int'(cyc >= 30), 1);
      expect_reg("R11 result status", 4, 8'hD0);
      expect_res7("R11", 8'h04, 8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h02);
   endtask

   task automatic pio_sectors(input string tag, input int first, input int nsec);
      logic [7:0] d;
      for (int s = first; s < first + nsec; s++) begin
         int miss = 0;
         for (int j = 0; j < 512; j++) begin
            rd(5, d);
            if (d != 8'((s + j) % 256)) miss++;
            if (s == first + nsec - 1 && j == 510) check({tag, " R8 irq low during data"}, int'(irq), 0);
         end
         check($sformatf("%s R7 sector %0d mismatches", tag, s), miss, 0);
      end
      settle();
   endtask

   task automatic t_pio();
      media_present = 1'b1;
      wr(2, 8'h00);
      wr(5, 8'h0F); wr(5, 8'h00); wr(5, 8'h00);
      settle();
      sense_expect("R7 prep", 8'h20, 8'h00);
      send_rw(8'hE6, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02);
      expect_reg("R7 data status", 4, 8'hF0);
      pio_sectors("pio2", 1, 2);
      expect_reg("R8 result status", 4, 8'hD0);
      check("R8 irq high", int'(irq), 1);
      expect_res7("R8 mt end", 8'h04, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h02);
   endtask

   task automatic t_over();
      send_rw(8'hE6, 8'h00, 8'h00, 8'h00, 8'h11, 8'h13);
      expect_reg("R9 data status", 4, 8'hF0);
      pio_sectors("over", 17, 2);
      expect_reg("R9 result status", 4, 8'hD0);
      expect_res7("R9 over", 8'h40, 8'h80, 8'h00, 8'h00, 8'h00, 8'h12, 8'h02);
   endtask

   task automatic t_no_data_phase();
      send_rw(8'h16, 8'h00, 8'h02, 8'h00, 8'h01, 8'h03);
      expect_reg("R10 verify status", 4, 8'hD0);
      expect_res7("R10 verify", 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h04, 8'h02);
      wr(2, 8'h08);
      send_rw(8'hE6, 8'h00, 8'h01, 8'h00, 8'h01, 8'h05);
      expect_reg("R10 dma status", 4, 8'hD0);
      expect_res7("R10 dma read", 8'h04, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h02);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_and_sense_idle();
      t_no_media();
      t_seeks();
      t_read_id();
      t_pio();
      t_over();
      t_no_data_phase();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule